// File: doc/BRIEF.md
# Shadow-Stack-Aware Page Table Walker

This block walks a three-level radix page table (4 KiB pages, 8-byte entries) to translate one virtual address at a time. A walk starts from a root table page number, the virtual address, an access class and the shadow-stack enable bits. The walker reads one table entry per level over a simple request/response memory port. It either descends through pointer entries or stops on a leaf. It reports a physical address or a fault, together with whether the fault is a page fault or an access fault and which access type it is charged to.

The leaf checks follow shadow-stack memory rules. The write-only encoding of the permission bits marks a shadow-stack page, but only when the enable that applies to the current translation context is set. Shadow-stack instructions may touch only such pages. Ordinary stores and instruction fetches may not touch them. Every fault raised for a shadow-stack instruction is charged to the store/AMO type. Superpage leaves are translated by splicing virtual page number fields into the low part of the physical page number.

Top module: `ss_ptw`

## Requirements
- R1: During and right after reset, `req_valid_o`, `busy_o`, `done_o`, `fault_o`, `fault_access_o` are 0, `fault_type_o` is 0 and `paddr_o` is 0.
- R2: A walk begins at level 2. The entry address for level L is (table page number × 4096) + (VA[12+9L+8:12+9L] × 8), starting from `root_ppn_i`. Only one read is outstanding, and `req_valid_o`/`req_addr_o` hold steady until `req_ready_i` is seen.
- R3: An entry with V=1 and X,W,R all 0 is a pointer. The next table page is its PPN field (bits 53:10) and the level drops by one. Such an entry at level 0 gives a page fault.
- R4: An entry with V (bit 0) clear, or any of bits 63:54 set, gives a page fault.
- R5: W (bit 2) set with R (bit 1) clear is reserved and gives a page fault. The one exception is X,W,R = 010 while the applicable enable is 1: `sse_h_i` when `virt_i`=1, else `sse_m_i`.
- R6: A shadow-stack access (`acc_i` 3 = shadow load, 4 = shadow store) that reaches a leaf with X,W,R ≠ 010 gives an access fault.
- R7: A plain store (`acc_i`=1) or a fetch (`acc_i`=2) that reaches a leaf with X,W,R = 010 gives an access fault of its own type.
- R8: On other leaves, a load (`acc_i`=0 or 5..7) needs R=1 or X,W,R=010, a store needs W=1, and a fetch needs X (bit 3)=1. A failed check gives a page fault.
- R9: `fault_access_o` is 0 for a page fault and 1 for an access fault. `fault_type_o` is 0 load, 1 store, 2 fetch. Any fault on a shadow-stack access reports type 1.
- R10: A successful walk ending on a level-L leaf returns the leaf PPN with its low 9·L bits replaced by VA[12+9L-1:12], followed by VA[11:0].
- R11: `done_o` pulses for one cycle, one cycle after the final response. `start_i` is ignored while `busy_o`=1. Results hold until the next walk finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a walk (accepted when idle) |
| vaddr_i | input | 39 | Virtual address to translate |
| root_ppn_i | input | 44 | Page number of the root table |
| acc_i | input | 3 | Access class: 0 load, 1 store, 2 fetch, 3 shadow load, 4 shadow store |
| virt_i | input | 1 | Virtualized translation context |
| sse_m_i | input | 1 | Shadow-stack enable, non-virtualized context |
| sse_h_i | input | 1 | Shadow-stack enable, virtualized context |
| req_valid_o | output | 1 | Entry read request |
| req_ready_i | input | 1 | Memory accepts the request |
| req_addr_o | output | 56 | Byte address of the entry |
| rsp_valid_i | input | 1 | Entry data returned |
| rsp_pte_i | input | 64 | Returned entry |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Last walk faulted |
| fault_access_o | output | 1 | Fault is an access fault (else page fault) |
| fault_type_o | output | 2 | Fault access type |
| paddr_o | output | 56 | Translated physical address |

## Verification
On a single response cycle the entry is judged by two separate checks: the reserved-encoding check, and the shadow-stack class rules that choose between an access fault and a page fault. Both can claim the same write-only leaf. The bench provokes this by sending shadow-stack accesses to an X,W,R=010 leaf while the applicable enable is cleared, including a case where the other context's enable is set. The expected result is a store-type page fault, not an access fault. A second overlap comes from a new start request that arrives while a walk is still in flight. The bench checks that the finished result still belongs to the first address.

// File: rtl/ss_ptw_pkg.sv
package ss_ptw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } walk_state_e;

  typedef enum logic [2:0] {
    ACC_LOAD     = 3'd0,
    ACC_STORE    = 3'd1,
    ACC_FETCH    = 3'd2,
    ACC_SS_LOAD  = 3'd3,
    ACC_SS_STORE = 3'd4
  } acc_class_e;

  typedef enum logic [1:0] {
    FT_LOAD  = 2'd0,
    FT_STORE = 2'd1,
    FT_FETCH = 2'd2
  } fault_type_e;

  localparam logic [2:0] XWR_SHADOW = 3'b010;
  localparam logic [2:0] XWR_PTR    = 3'b000;

  typedef struct packed {
    logic        descend;
    logic        fault;
    logic        access;
    fault_type_e ftype;
  } pte_verdict_t;

endpackage

// File: rtl/ss_ptw_judge.sv
module ss_ptw_judge
  import ss_ptw_pkg::*;
#(
  parameter int PTE_W   = 64,
  parameter int RSV_LSB = 54
) (
  input  logic [PTE_W-1:0] pte_i,
  input  logic [2:0]       acc_i,
  input  logic             sse_i,
  input  logic             last_level_i,
  output pte_verdict_t     verdict_o
);

  logic       pv, pr, pw, px;
  logic [2:0] xwr;
  logic       is_ss;
  logic       cls_store, cls_fetch;
  logic       rsv_hit;
  logic       perm_ok;

  assign pv  = pte_i[0];
  assign pr  = pte_i[1];
  assign pw  = pte_i[2];
  assign px  = pte_i[3];
  assign xwr = {px, pw, pr};

  assign is_ss     = (acc_i == ACC_SS_LOAD) || (acc_i == ACC_SS_STORE);
  assign cls_store = (acc_i == ACC_STORE);
  assign cls_fetch = (acc_i == ACC_FETCH);
  assign rsv_hit   = |pte_i[PTE_W-1:RSV_LSB];

  always_comb begin
    if (cls_store)      perm_ok = pw;
    else if (cls_fetch) perm_ok = px;
    else                perm_ok = pr || (xwr == XWR_SHADOW);
  end

  always_comb begin
    verdict_o.descend = 1'b0;
    verdict_o.fault   = 1'b0;
    verdict_o.access  = 1'b0;
    if (is_ss || cls_store) verdict_o.ftype = FT_STORE;
    else if (cls_fetch)     verdict_o.ftype = FT_FETCH;
    else                    verdict_o.ftype = FT_LOAD;

    if (!pv || rsv_hit) begin
      verdict_o.fault = 1'b1;
    end else if (pw && !pr && !((xwr == XWR_SHADOW) && sse_i)) begin
      verdict_o.fault = 1'b1;
    end else if (xwr == XWR_PTR) begin
      if (last_level_i) verdict_o.fault   = 1'b1;
      else              verdict_o.descend = 1'b1;
    end else if (is_ss && (xwr != XWR_SHADOW)) begin
      verdict_o.fault  = 1'b1;
      verdict_o.access = 1'b1;
    end else if (!is_ss && (xwr == XWR_SHADOW) && (cls_store || cls_fetch)) begin
      verdict_o.fault  = 1'b1;
      verdict_o.access = 1'b1;
    end else if (!is_ss && !perm_ok) begin
      verdict_o.fault = 1'b1;
    end
  end

endmodule

// File: rtl/ss_ptw_addr.sv
module ss_ptw_addr #(
  parameter int LEVELS  = 3,
  parameter int IDX_W   = 9,
  parameter int PG_BITS = 12,
  parameter int PPN_W   = 44,
  parameter int ENT_LG2 = 3,
  localparam int VA_W   = PG_BITS + IDX_W * LEVELS,
  localparam int PA_W   = PPN_W + PG_BITS,
  localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [PPN_W-1:0] table_ppn_i,
  input  logic [PPN_W-1:0] leaf_ppn_i,
  input  logic [LVL_W-1:0] level_i,
  output logic [PA_W-1:0]  pte_addr_o,
  output logic [PA_W-1:0]  paddr_o
);

  logic [IDX_W-1:0] vpn [LEVELS];
  logic [PPN_W-1:0] spliced;

  for (genvar g = 0; g < LEVELS; g++) begin : g_vpn
    assign vpn[g] = vaddr_i[PG_BITS + g*IDX_W +: IDX_W];
    assign spliced[g*IDX_W +: IDX_W] =
      (LVL_W'(g) < level_i) ? vpn[g] : leaf_ppn_i[g*IDX_W +: IDX_W];
  end

  if (PPN_W > IDX_W * LEVELS) begin : g_upper
    assign spliced[PPN_W-1:IDX_W*LEVELS] = leaf_ppn_i[PPN_W-1:IDX_W*LEVELS];
  end

  assign pte_addr_o = {table_ppn_i, {(PG_BITS-IDX_W-ENT_LG2){1'b0}}, vpn[level_i], {ENT_LG2{1'b0}}};
  assign paddr_o    = {spliced, vaddr_i[PG_BITS-1:0]};

endmodule

// File: rtl/ss_ptw_ctl.sv
module ss_ptw_ctl
  import ss_ptw_pkg::*;
#(
  parameter int LEVELS = 3,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             req_ready_i,
  input  logic             rsp_valid_i,
  input  logic             descend_i,
  output walk_state_e      state_o,
  output logic [LVL_W-1:0] level_o,
  output logic             accept_o,
  output logic             take_o,
  output logic             step_o
);

  walk_state_e      state_q, state_d;
  logic [LVL_W-1:0] level_q, level_d;
  logic             level_en;

  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign take_o   = (state_q == ST_WAIT) && rsp_valid_i;
  assign step_o   = take_o && descend_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i)     state_d = ST_REQ;
      ST_REQ:  if (req_ready_i) state_d = ST_WAIT;
      ST_WAIT: if (rsp_valid_i) state_d = descend_i ? ST_REQ : ST_DONE;
      ST_DONE:                  state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    level_en = accept_o || step_o;
    level_d  = accept_o ? LVL_W'(LEVELS - 1) : level_q - LVL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      level_q <= '0;
    end else begin
      state_q <= state_d;
      if (level_en) level_q <= level_d;
    end
  end

  assign state_o = state_q;
  assign level_o = level_q;

endmodule

// File: rtl/ss_ptw.sv
module ss_ptw
  import ss_ptw_pkg::*;
#(
  parameter int LEVELS   = 3,
  parameter int IDX_W    = 9,
  parameter int PG_BITS  = 12,
  parameter int PPN_W    = 44,
  parameter int PTE_W    = 64,
  parameter int PPN_LSB  = 10,
  parameter int ENT_LG2  = 3,
  localparam int VA_W    = PG_BITS + IDX_W * LEVELS,
  localparam int PA_W    = PPN_W + PG_BITS,
  localparam int RSV_LSB = PPN_LSB + PPN_W,
  localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [PPN_W-1:0] root_ppn_i,
  input  logic [2:0]       acc_i,
  input  logic             virt_i,
  input  logic             sse_m_i,
  input  logic             sse_h_i,
  output logic             req_valid_o,
  input  logic             req_ready_i,
  output logic [PA_W-1:0]  req_addr_o,
  input  logic             rsp_valid_i,
  input  logic [PTE_W-1:0] rsp_pte_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             fault_o,
  output logic             fault_access_o,
  output logic [1:0]       fault_type_o,
  output logic [PA_W-1:0]  paddr_o
);

  walk_state_e      state;
  logic [LVL_W-1:0] level;
  logic             accept, take, step, finish;
  pte_verdict_t     verdict;

  logic [VA_W-1:0]  va_q;
  logic [2:0]       acc_q;
  logic             sse_q;
  logic [PPN_W-1:0] table_q, table_d;
  logic             table_en;

  logic             fault_q, fault_acc_q;
  logic [1:0]       ftype_q;
  logic [PA_W-1:0]  paddr_q, paddr_d, pte_addr;
  logic [PPN_W-1:0] rsp_ppn;

  assign rsp_ppn = rsp_pte_i[PPN_LSB +: PPN_W];

  ss_ptw_ctl #(.LEVELS(LEVELS)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .req_ready_i (req_ready_i),
    .rsp_valid_i (rsp_valid_i),
    .descend_i   (verdict.descend),
    .state_o     (state),
    .level_o     (level),
    .accept_o    (accept),
    .take_o      (take),
    .step_o      (step)
  );

  ss_ptw_judge #(.PTE_W(PTE_W), .RSV_LSB(RSV_LSB)) u_judge (
    .pte_i        (rsp_pte_i),
    .acc_i        (acc_q),
    .sse_i        (sse_q),
    .last_level_i (level == '0),
    .verdict_o    (verdict)
  );

  ss_ptw_addr #(
    .LEVELS (LEVELS),
    .IDX_W  (IDX_W),
    .PG_BITS(PG_BITS),
    .PPN_W  (PPN_W),
    .ENT_LG2(ENT_LG2)
  ) u_addr (
    .vaddr_i     (va_q),
    .table_ppn_i (table_q),
    .leaf_ppn_i  (rsp_ppn),
    .level_i     (level),
    .pte_addr_o  (pte_addr),
    .paddr_o     (paddr_d)
  );

  assign finish   = take && !verdict.descend;
  assign table_en = accept || step;
  assign table_d  = accept ? root_ppn_i : rsp_ppn;

  // walk context
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q  <= '0;
      acc_q <= '0;
      sse_q <= 1'b0;
    end else if (accept) begin
      va_q  <= vaddr_i;
      acc_q <= acc_i;
      sse_q <= virt_i ? sse_h_i : sse_m_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        table_q <= '0;
    else if (table_en) table_q <= table_d;
  end

  // result registers, loaded once per finished walk
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q     <= 1'b0;
      fault_acc_q <= 1'b0;
      ftype_q     <= 2'd0;
      paddr_q     <= '0;
    end else if (finish) begin
      fault_q     <= verdict.fault;
      fault_acc_q <= verdict.fault && verdict.access;
      ftype_q     <= verdict.fault ? verdict.ftype : 2'd0;
      paddr_q     <= verdict.fault ? '0 : paddr_d;
    end
  end

  assign req_valid_o    = (state == ST_REQ);
  assign req_addr_o     = (state == ST_REQ) ? pte_addr : '0;
  assign busy_o         = (state != ST_IDLE);
  assign done_o         = (state == ST_DONE);
  assign fault_o        = fault_q;
  assign fault_access_o = fault_acc_q;
  assign fault_type_o   = ftype_q;
  assign paddr_o        = paddr_q;

endmodule

// File: rtl/ss_ptw_chk.sv
module ss_ptw_chk #(
  parameter int PA_W    = 56,
  parameter int PG_BITS = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid_o,
  input logic               req_ready_i,
  input logic [PA_W-1:0]    req_addr_o,
  input logic               rsp_valid_i,
  input logic               busy_o,
  input logic               done_o,
  input logic               fault_o,
  input logic [1:0]         fault_type_o,
  input logic [PA_W-1:0]    paddr_o,
  input logic [2:0]         acc_q,
  input logic [PG_BITS-1:0] va_off
);

  // R1: reset state seen at the ports
  always @(posedge clk) begin
    if (!rst_n) begin
      a_reset_quiet_r1: assert (!req_valid_o && !done_o && !busy_o && !fault_o)
        else $error("reset state not quiet");
    end
  end

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_after_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(rsp_valid_i));

  p_no_req_when_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !req_valid_o);

  p_ss_fault_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && fault_o && (acc_q == 3'd3 || acc_q == 3'd4) |-> fault_type_o == 2'd1);

  p_offset_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !fault_o |-> paddr_o[PG_BITS-1:0] == va_off);

endmodule

bind ss_ptw ss_ptw_chk #(.PA_W(PA_W), .PG_BITS(PG_BITS)) u_ss_ptw_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid_o  (req_valid_o),
  .req_ready_i  (req_ready_i),
  .req_addr_o   (req_addr_o),
  .rsp_valid_i  (rsp_valid_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .fault_o      (fault_o),
  .fault_type_o (fault_type_o),
  .paddr_o      (paddr_o),
  .acc_q        (acc_q),
  .va_off       (va_q[PG_BITS-1:0])
);

// File: tb/tb_ss_ptw.sv
module tb_ss_ptw;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam logic [43:0] ROOT = 44'h100;
  localparam logic [43:0] LEAF = 44'h0AB_CDEF_1234;

  logic        clk, rst_n, start_i, virt_i, sse_m_i, sse_h_i;
  logic [38:0] vaddr_i;
  logic [43:0] root_ppn_i;
  logic [2:0]  acc_i;
  logic        req_valid_o, req_ready_i, rsp_valid_i;
  logic [55:0] req_addr_o, paddr_o;
  logic [63:0] rsp_pte_i;
  logic        busy_o, done_o, fault_o, fault_access_o;
  logic [1:0]  fault_type_o;

  ss_ptw dut (.*);

  int n_chk = 0, n_bad = 0;
  logic [63:0] mem [longint unsigned];
  logic        stall_mode = 1'b0;
  logic        pend = 1'b0;
  logic [55:0] pend_addr = '0;

  typedef struct packed {
    logic [2:0] acc; logic virt; logic sm; logic sh;
    logic [2:0] xwr; logic [1:0] lvl; logic vb; logic rsv;
    logic ef; logic ea; logic [1:0] et;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{3'd0,1'b0,1'b0,1'b0,3'b001,2'd0,1'b1,1'b0,1'b0,1'b0,2'd0},
    '{3'd1,1'b0,1'b0,1'b0,3'b011,2'd0,1'b1,1'b0,1'b0,1'b0,2'd0},
    '{3'd2,1'b0,1'b0,1'b0,3'b100,2'd1,1'b1,1'b0,1'b0,1'b0,2'd0},
    '{3'd4,1'b0,1'b1,1'b0,3'b010,2'd0,1'b1,1'b0,1'b0,1'b0,2'd0},
    '{3'd3,1'b0,1'b1,1'b0,3'b010,2'd2,1'b1,1'b0,1'b0,1'b0,2'd0},
    '{3'd4,1'b0,1'b0,1'b0,3'b010,2'd0,1'b1,1'b0,1'b1,1'b0,2'd1},
    '{3'd3,1'b1,1'b1,1'b0,3'b010,2'd1,1'b1,1'b0,1'b1,1'b0,2'd1},
    '{3'd3,1'b1,1'b0,1'b1,3'b010,2'd0,1'b1,1'b0,1'b0,1'b0,2'd0},
    '{3'd4,1'b0,1'b1,1'b0,3'b011,2'd0,1'b1,1'b0,1'b1,1'b1,2'd1},
    '{3'd3,1'b0,1'b1,1'b0,3'b001,2'd0,1'b1,1'b0,1'b1,1'b1,2'd1},
    '{3'd1,1'b0,1'b1,1'b0,3'b010,2'd0,1'b1,1'b0,1'b1,1'b1,2'd1},
    '{3'd2,1'b0,1'b1,1'b0,3'b010,2'd0,1'b1,1'b0,1'b1,1'b1,2'd2},
    '{3'd0,1'b0,1'b1,1'b0,3'b010,2'd1,1'b1,1'b0,1'b0,1'b0,2'd0},
    '{3'd0,1'b0,1'b1,1'b0,3'b110,2'd0,1'b1,1'b0,1'b1,1'b0,2'd0},
    '{3'd1,1'b0,1'b0,1'b0,3'b001,2'd0,1'b1,1'b0,1'b1,1'b0,2'd1},
    '{3'd2,1'b0,1'b0,1'b0,3'b011,2'd0,1'b1,1'b0,1'b1,1'b0,2'd2},
    '{3'd0,1'b0,1'b0,1'b0,3'b001,2'd0,1'b0,1'b0,1'b1,1'b0,2'd0},
    '{3'd3,1'b0,1'b1,1'b0,3'b010,2'd0,1'b0,1'b0,1'b1,1'b0,2'd1},
    '{3'd0,1'b0,1'b0,1'b0,3'b001,2'd0,1'b1,1'b1,1'b1,1'b0,2'd0},
    '{3'd0,1'b0,1'b0,1'b0,3'b000,2'd0,1'b1,1'b0,1'b1,1'b0,2'd0},
    '{3'd5,1'b0,1'b0,1'b0,3'b001,2'd0,1'b1,1'b0,1'b0,1'b0,2'd0}
  };

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: one-cycle response, optional ready stalls
  always @(negedge clk) begin
    rsp_valid_i = pend;
    rsp_pte_i   = (pend && mem.exists(longint'(pend_addr))) ? mem[longint'(pend_addr)] : 64'd0;
    req_ready_i = stall_mode ? ~req_ready_i : 1'b1;
    pend        = req_valid_o && req_ready_i;
    pend_addr   = req_addr_o;
  end

  function automatic logic [8:0] vpn_of(input logic [38:0] va, input int l);
    return va[12 + 9*l +: 9];
  endfunction

  function automatic logic [38:0] va_of(input int i);
    return {9'(3 + i*7), 9'(1 + i*5), 9'(2 + i*3), 12'(12'h5A0 + i)};
  endfunction

  function automatic logic [55:0] exp_pa(input logic [38:0] va, input int l);
    logic [43:0] p = LEAF;
    for (int g = 0; g < l; g++) p[g*9 +: 9] = vpn_of(va, g);
    return {p, va[11:0]};
  endfunction

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic build(input logic [38:0] va, input int leaf_lvl, input logic [63:0] leaf_pte);
    logic [43:0] base = ROOT;
    logic [43:0] nxt;
    mem.delete();
    for (int l = 2; l > leaf_lvl; l--) begin
      nxt = 44'h200 + 44'(l);
      mem[longint'({base, vpn_of(va, l), 3'b000})] = {10'd0, nxt, 10'h001};
      base = nxt;
    end
    mem[longint'({base, vpn_of(va, leaf_lvl), 3'b000})] = leaf_pte;
  endtask

  task automatic launch(input logic [38:0] va, input logic [2:0] acc, input logic v, input logic sm, input logic sh);
    @(negedge clk);
    vaddr_i = va; acc_i = acc; virt_i = v; sse_m_i = sm; sse_h_i = sh;
    root_ppn_i = ROOT; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output logic seen);
    seen = 1'b0;
    for (int k = 0; k < 100 && !seen; k++) begin
      if (done_o) seen = 1'b1;
      else @(negedge clk);
    end
  endtask

  function automatic string tag_of(input vec_t v);
    if (!v.vb || v.rsv)                 return "R4";
    if (v.xwr == 3'b000)                return "R3";
    if (v.xwr[1] && !v.xwr[0])          return "R5";
    if (v.ef && v.ea && v.acc >= 3'd3)  return "R6";
    if (v.ef && v.ea)                   return "R7";
    if (v.ef)                           return "R8";
    return "R10";
  endfunction

  initial begin
    int cyc = 0;
    while (cyc < WATCHDOG) begin @(posedge clk); cyc++; end
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic seen;
    logic [55:0] held;
    rst_n = 1'b0; start_i = 1'b0; vaddr_i = '0; root_ppn_i = '0; acc_i = '0;
    virt_i = 1'b0; sse_m_i = 1'b0; sse_h_i = 1'b0;
    req_ready_i = 1'b1; rsp_valid_i = 1'b0; rsp_pte_i = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!req_valid_o && !busy_o && !done_o, "R1 control", {61'd0, req_valid_o, busy_o, done_o}, 64'd0);
    check(!fault_o && !fault_access_o && fault_type_o == 2'd0 && paddr_o == '0, "R1 result",
          {paddr_o, fault_o, fault_access_o, fault_type_o}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // table-driven walks
    for (int i = 0; i < NV; i++) begin
      logic [38:0] va = va_of(i);
      vec_t v = VEC[i];
      build(va, int'(v.lvl), {v.rsv ? 10'h200 : 10'h000, LEAF, 6'd0, v.xwr, v.vb});
      launch(va, v.acc, v.virt, v.sm, v.sh);
      wait_done(seen);
      check(seen, "R11 done seen", 64'(seen), 64'd1);
      check(fault_o == v.ef && fault_access_o == v.ea, tag_of(v),
            {62'd0, fault_o, fault_access_o}, {62'd0, v.ef, v.ea});
      if (v.ef) check(fault_type_o == v.et, "R9 type", 64'(fault_type_o), 64'(v.et));
      else      check(paddr_o == exp_pa(va, int'(v.lvl)), "R10 paddr", 64'(paddr_o), 64'(exp_pa(va, int'(v.lvl))));
      @(negedge clk);
      check(!done_o, "R11 single pulse", 64'(done_o), 64'd0);
    end

    // R2: first request address and order
    begin
      logic [38:0] va = va_of(30);
      build(va, 0, {10'd0, LEAF, 6'd0, 3'b011, 1'b1});
      launch(va, 3'd0, 1'b0, 1'b0, 1'b0);
      check(req_valid_o && req_addr_o == {ROOT, vpn_of(va, 2), 3'b000}, "R2 root addr",
            64'(req_addr_o), 64'({ROOT, vpn_of(va, 2), 3'b000}));
      wait_done(seen);
      check(!fault_o && paddr_o == exp_pa(va, 0), "R2 walk result", 64'(paddr_o), 64'(exp_pa(va, 0)));
    end

    // R2 with ready stalls
    stall_mode = 1'b1;
    begin
      logic [38:0] va = va_of(31);
      build(va, 0, {10'd0, LEAF, 6'd0, 3'b001, 1'b1});
      launch(va, 3'd0, 1'b0, 1'b0, 1'b0);
      wait_done(seen);
      check(seen && !fault_o && paddr_o == exp_pa(va, 0), "R2 stalled walk", 64'(paddr_o), 64'(exp_pa(va, 0)));
    end
    stall_mode = 1'b0;
    repeat (2) @(negedge clk);

    // R11: start during a walk is ignored; results hold afterwards
    begin
      logic [38:0] va = va_of(32);
      build(va, 0, {10'd0, LEAF, 6'd0, 3'b001, 1'b1});
      launch(va, 3'd0, 1'b0, 1'b0, 1'b0);
      vaddr_i = va_of(40); acc_i = 3'd2; start_i = 1'b1;
      wait_done(seen);
      start_i = 1'b0;
      check(!fault_o && paddr_o == exp_pa(va, 0), "R11 start ignored", 64'(paddr_o), 64'(exp_pa(va, 0)));
      held = paddr_o;
      repeat (3) @(negedge clk);
      check(!busy_o, "R11 idle after", 64'(busy_o), 64'd0);
      check(paddr_o == held && !fault_o, "R11 result held", 64'(paddr_o), 64'(held));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule